// File: doc/BRIEF.md
# Line-Buffer Instruction Sequencer

This block drives a bank of rolling line buffers for a streaming image pipeline that takes one multi-pixel block per cycle. The geometry of each image line is not fixed when the chip is built. A host loads a short list of per-line control words into a small instruction RAM, along with an image height, and then issues a start strobe. From then on the sequencer accepts input blocks, counts them against the block count of the current line, and fetches a new word each time a line ends. When a word carries the wrap flag, fetching returns to the head of the list. The list therefore only has to cover one period of the line-to-block alignment pattern: LCM(line width, block size) / line width lines. For 44-pixel lines and 16-pixel blocks that is 4 words.

The line buffers are filled in turn, so each new line replaces the oldest one. Every bank in every line buffer has its own write-address counter. On the first block of a line the sequencer clears the counters of the buffer being written, and on every later block of that line it steps them by one. The read address shared by all buffers is taken from the counters of the buffer now being written, through a multiplexer steered by that buffer's index. The fields of each word are held in their own registers, which change only when the first block of a line is accepted. The start-bank, intra-bank offset and spill-count fields are brought out for the pixel datapath.

Top module: `lbseq_top`

## Requirements
- R1: An instruction word packs its fields from bit 0 upward: start bank [1:0], intra-bank offset [4:2], spill (remainder) count [9:5], block count [15:10], wrap flag [16]. The cycle after the first block of a line is accepted, `startBank`, `bankOff` and `remCnt` show the fields of the word at the current fetch address.
- R2: A line lasts exactly block-count accepted blocks. For each accepted block, `blkAck` is high in the following cycle. `firstBlk` marks the first block of the line and `lastBlk` marks the last. The next line uses the word at the next fetch address.
- R3: After a line whose word has the wrap flag set, the next line uses the word at address 0.
- R4: Lines go to line buffers 0, 1, ..., NUM_LB-1 and then back to 0. `curLb` shows the buffer that took the acknowledged block.
- R5: The first block of a line clears every bank counter of its buffer to 0, and each later block of the line steps them by one. After block k of a line (counting from 0), `rdAddr` shows k in every bank. The counters of the other buffers, visible on `wrAddr` at offset (lb*NUM_BANK+bank)*ADDR_W, keep their values.
- R6: Once the number of completed lines equals the height register, `inReady` goes low.
- R7: A host write (instruction or height) drives `inReady` low in the next cycle. A start strobe without a host write raises `inReady` in the next cycle and restarts fetching at address 0, filling at buffer 0 with a zero line count. A start in the same cycle as a host write is ignored.
- R8: `startBank`, `bankOff` and `remCnt` stay unchanged over the non-first blocks of a line.
- R9: A block offered while `inReady` is low is ignored. No `blkAck` follows, and no address counter moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostHeight | input | 1 | 1: write height register, 0: write instruction RAM |
| hostAddr | input | 3 | Instruction RAM address for host writes |
| hostData | input | 17 | Instruction word, or height in the low 12 bits |
| start | input | 1 | Begin processing an image |
| blkValid | input | 1 | An input block is offered this cycle |
| inReady | output | 1 | Blocks are accepted this cycle |
| blkAck | output | 1 | A block was accepted in the previous cycle |
| firstBlk | output | 1 | Acknowledged block was first of its line |
| lastBlk | output | 1 | Acknowledged block was last of its line |
| curLb | output | 2 | Line buffer written by the acknowledged block |
| startBank | output | 2 | Start bank field of the current line |
| bankOff | output | 3 | Intra-bank offset field of the current line |
| remCnt | output | 5 | Spill count field of the current line |
| rdAddr | output | 18 | Shared read address, one 6-bit address per bank |
| wrAddr | output | 54 | All bank write-address counters, 6 bits each |

## Verification
The assertions assume that the host never loads a word with a block count of zero, never writes a height of zero, and always marks the last word of a list with the wrap flag. The bench keeps within these limits: every list it loads covers one whole period and ends with a wrapped word, and every height it writes is at least one. Host writes and start strobes are only issued while no image is in flight, except in the test that checks a write forces `inReady` low. The test that offers blocks to an idle block only does so when `inReady` is low.

// File: rtl/lbseq_pkg.sv
package lbseq_pkg;
  // width of the line-buffer select carried in the strobe struct
  localparam int LB_SEL_W = 4;

  // strobes from the control to the address datapath
  typedef struct packed {
    logic                inc;  // step every bank counter of lb
    logic                clr;  // clear every bank counter of lb
    logic [LB_SEL_W-1:0] lb;   // line buffer being written
  } addrStrobe_t;
endpackage

// File: rtl/lbseq_ctrl.sv
module lbseq_ctrl
  import lbseq_pkg::*;
#(
  parameter int NUM_LB     = 3,
  parameter int NUM_BANK   = 3,
  parameter int DEPTH      = 8,
  parameter int MAX_BLOCKS = 48,
  parameter int HEIGHT_W   = 12,
  parameter int OFF_W      = 3,
  parameter int REM_W      = 5,
  localparam int LB_W      = (NUM_LB > 1) ? $clog2(NUM_LB) : 1,
  localparam int BANK_W    = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int BLK_W     = $clog2(MAX_BLOCKS + 1),
  localparam int IA_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int INSTR_W   = BANK_W + OFF_W + REM_W + BLK_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWr,
  input  logic               hostHeight,
  input  logic [IA_W-1:0]    hostAddr,
  input  logic [INSTR_W-1:0] hostData,
  input  logic               start,
  input  logic               blkValid,
  output logic               inReady,
  output addrStrobe_t        stb,
  output logic               blkAck,
  output logic               firstBlk,
  output logic               lastBlk,
  output logic [LB_W-1:0]    curLb,
  output logic [BANK_W-1:0]  startBank,
  output logic [OFF_W-1:0]   bankOff,
  output logic [REM_W-1:0]   remCnt
);
  // field positions inside an instruction word
  localparam int P_OFF  = BANK_W;
  localparam int P_REM  = P_OFF + OFF_W;
  localparam int P_BLK  = P_REM + REM_W;
  localparam int P_WRAP = P_BLK + BLK_W;

  logic [INSTR_W-1:0]  iram [DEPTH];
  logic [HEIGHT_W-1:0] heightReg;
  logic [IA_W-1:0]     fetchAddr;
  logic [BLK_W-1:0]    blkIdx;
  logic [LB_W-1:0]     lineLb;
  logic [HEIGHT_W-1:0] lineCnt;
  logic [BLK_W-1:0]    regBlocks;
  logic                regWrap;

  logic [INSTR_W-1:0]  word;
  logic                first, acc, endLine, eWrap;
  logic [BLK_W-1:0]    eBlocks;

  always_ff @(posedge clk) begin
    if (hostWr && !hostHeight) iram[hostAddr] <= hostData;
  end

  assign word    = iram[fetchAddr];
  assign first   = (blkIdx == '0);
  assign acc     = blkValid && inReady && !hostWr && !start;
  assign eBlocks = first ? word[P_BLK +: BLK_W] : regBlocks;
  assign eWrap   = first ? word[P_WRAP] : regWrap;
  assign endLine = acc && (blkIdx == (eBlocks - BLK_W'(1)));

  assign stb.inc = acc && !first;
  assign stb.clr = acc && first;
  assign stb.lb  = LB_SEL_W'(lineLb);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inReady   <= 1'b0;
      heightReg <= HEIGHT_W'(1);
      fetchAddr <= '0;
      blkIdx    <= '0;
      lineLb    <= '0;
      lineCnt   <= '0;
      regBlocks <= '0;
      regWrap   <= 1'b0;
      startBank <= '0;
      bankOff   <= '0;
      remCnt    <= '0;
      blkAck    <= 1'b0;
      firstBlk  <= 1'b0;
      lastBlk   <= 1'b0;
      curLb     <= '0;
    end else begin
      blkAck <= acc;
      if (hostWr) begin
        inReady <= 1'b0;
        if (hostHeight) heightReg <= hostData[HEIGHT_W-1:0];
      end else if (start) begin
        inReady   <= 1'b1;
        fetchAddr <= '0;
        blkIdx    <= '0;
        lineLb    <= '0;
        lineCnt   <= '0;
      end else if (acc) begin
        if (first) begin
          startBank <= word[BANK_W-1:0];
          bankOff   <= word[P_OFF +: OFF_W];
          remCnt    <= word[P_REM +: REM_W];
          regBlocks <= word[P_BLK +: BLK_W];
          regWrap   <= word[P_WRAP];
        end
        firstBlk <= first;
        lastBlk  <= endLine;
        curLb    <= lineLb;
        if (endLine) begin
          blkIdx    <= '0;
          fetchAddr <= (eWrap || fetchAddr == IA_W'(DEPTH - 1)) ? '0 : fetchAddr + IA_W'(1);
          lineLb    <= (lineLb == LB_W'(NUM_LB - 1)) ? '0 : lineLb + LB_W'(1);
          lineCnt   <= lineCnt + HEIGHT_W'(1);
          if (lineCnt + HEIGHT_W'(1) == heightReg) inReady <= 1'b0;
        end else begin
          blkIdx <= blkIdx + BLK_W'(1);
        end
      end
    end
  end

  // R7: start without a host write opens the input
  assert_start_opens_R7: assert property (@(posedge clk) disable iff (!rstN)
    start && !hostWr |=> inReady);
  // R7: any host write closes the input
  assert_host_closes_R7: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> !inReady);
  // R3: a wrapped line sends fetching back to the head of the list
  assert_wrap_fetch_R3: assert property (@(posedge clk) disable iff (!rstN)
    endLine && eWrap |=> fetchAddr == '0);
  // R4: buffers are taken in turn
  assert_lb_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    endLine |=> lineLb == (($past(lineLb) == LB_W'(NUM_LB - 1)) ? '0 : $past(lineLb) + LB_W'(1)));
  // R8: fields hold over the rest of a line
  assert_fields_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    blkAck && !firstBlk |-> $stable(startBank) && $stable(bankOff) && $stable(remCnt));
  // R9: nothing is acknowledged while closed
  assert_closed_ignores_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> !blkAck);
  // R2: a line never runs past its block count
  assert_line_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    !first |-> blkIdx < regBlocks);
endmodule

// File: rtl/lbseq_addr.sv
module lbseq_addr
  import lbseq_pkg::*;
#(
  parameter int NUM_LB   = 3,
  parameter int NUM_BANK = 3,
  parameter int ADDR_W   = 6,
  localparam int LB_W    = (NUM_LB > 1) ? $clog2(NUM_LB) : 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  addrStrobe_t                        stb,
  output logic [NUM_BANK*ADDR_W-1:0]         rdAddr,
  output logic [NUM_LB*NUM_BANK*ADDR_W-1:0]  wrAddr
);
  logic [ADDR_W-1:0] cnt [NUM_LB][NUM_BANK];
  logic [LB_W-1:0]   activeLb;

  always_ff @(posedge clk) begin
    if (!rstN) activeLb <= '0;
    else if (stb.inc || stb.clr) activeLb <= LB_W'(stb.lb);
  end

  for (genvar l = 0; l < NUM_LB; l++) begin : g_lb
    for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rstN) cnt[l][b] <= '0;
        else if (stb.lb == LB_SEL_W'(l)) begin
          if (stb.clr)      cnt[l][b] <= '0;
          else if (stb.inc) cnt[l][b] <= cnt[l][b] + ADDR_W'(1);
        end
      end
      assign wrAddr[(l*NUM_BANK+b)*ADDR_W +: ADDR_W] = cnt[l][b];
    end
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_rd
    assign rdAddr[b*ADDR_W +: ADDR_W] = cnt[activeLb][b];
  end

  // R5: the first block of a line puts every bank at address 0
  assert_clr_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> rdAddr == '0);
  // R5: later blocks advance the shared read address by one
  assert_inc_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.inc && (stb.lb == LB_SEL_W'(activeLb)) |=>
      rdAddr[ADDR_W-1:0] == $past(rdAddr[ADDR_W-1:0]) + ADDR_W'(1));
  // R9: no strobe, no counter movement
  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.inc && !stb.clr |=> $stable(wrAddr));
endmodule

// File: rtl/lbseq_top.sv
module lbseq_top
  import lbseq_pkg::*;
#(
  parameter int NUM_LB     = 3,
  parameter int NUM_BANK   = 3,
  parameter int DEPTH      = 8,
  parameter int MAX_BLOCKS = 48,
  parameter int HEIGHT_W   = 12,
  parameter int OFF_W      = 3,
  parameter int REM_W      = 5,
  localparam int LB_W      = (NUM_LB > 1) ? $clog2(NUM_LB) : 1,
  localparam int BANK_W    = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1,
  localparam int BLK_W     = $clog2(MAX_BLOCKS + 1),
  localparam int ADDR_W    = $clog2(MAX_BLOCKS),
  localparam int IA_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int INSTR_W   = BANK_W + OFF_W + REM_W + BLK_W + 1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              hostWr,
  input  logic                              hostHeight,
  input  logic [IA_W-1:0]                   hostAddr,
  input  logic [INSTR_W-1:0]                hostData,
  input  logic                              start,
  input  logic                              blkValid,
  output logic                              inReady,
  output logic                              blkAck,
  output logic                              firstBlk,
  output logic                              lastBlk,
  output logic [LB_W-1:0]                   curLb,
  output logic [BANK_W-1:0]                 startBank,
  output logic [OFF_W-1:0]                  bankOff,
  output logic [REM_W-1:0]                  remCnt,
  output logic [NUM_BANK*ADDR_W-1:0]        rdAddr,
  output logic [NUM_LB*NUM_BANK*ADDR_W-1:0] wrAddr
);
  addrStrobe_t stb;

  lbseq_ctrl #(
    .NUM_LB(NUM_LB), .NUM_BANK(NUM_BANK), .DEPTH(DEPTH), .MAX_BLOCKS(MAX_BLOCKS),
    .HEIGHT_W(HEIGHT_W), .OFF_W(OFF_W), .REM_W(REM_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostHeight(hostHeight),
    .hostAddr(hostAddr), .hostData(hostData), .start(start), .blkValid(blkValid),
    .inReady(inReady), .stb(stb), .blkAck(blkAck), .firstBlk(firstBlk),
    .lastBlk(lastBlk), .curLb(curLb), .startBank(startBank), .bankOff(bankOff),
    .remCnt(remCnt)
  );

  lbseq_addr #(
    .NUM_LB(NUM_LB), .NUM_BANK(NUM_BANK), .ADDR_W(ADDR_W)
  ) u_addr (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr)
  );
endmodule

// File: tb/sim_lbseq_top.sv
module sim_lbseq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWr = 1'b0, hostHeight = 1'b0, start = 1'b0, blkValid = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [16:0] hostData = '0;
  logic        inReady, blkAck, firstBlk, lastBlk;
  logic [1:0]  curLb, startBank;
  logic [2:0]  bankOff;
  logic [4:0]  remCnt;
  logic [17:0] rdAddr;
  logic [53:0] wrAddr;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  lbseq_top u0 (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostHeight(hostHeight),
    .hostAddr(hostAddr), .hostData(hostData), .start(start), .blkValid(blkValid),
    .inReady(inReady), .blkAck(blkAck), .firstBlk(firstBlk), .lastBlk(lastBlk),
    .curLb(curLb), .startBank(startBank), .bankOff(bankOff), .remCnt(remCnt),
    .rdAddr(rdAddr), .wrAddr(wrAddr)
  );

  // one row per line: start bank, offset, spill, blocks, expected buffer
  typedef struct packed {
    logic [1:0] sb; logic [2:0] off; logic [4:0] rem; logic [5:0] blk; logic [1:0] lb;
  } lineRow_t;
  localparam lineRow_t LINES [6] = '{
    '{2'd0, 3'd0, 5'd4,  6'd3, 2'd0},
    '{2'd2, 3'd4, 5'd8,  6'd3, 2'd1},
    '{2'd1, 3'd0, 5'd12, 6'd3, 2'd2},
    '{2'd0, 3'd4, 5'd0,  6'd2, 2'd0},
    '{2'd0, 3'd0, 5'd4,  6'd3, 2'd1},
    '{2'd2, 3'd4, 5'd8,  6'd3, 2'd2}
  };

  function automatic logic [16:0] mk(logic [1:0] sb, logic [2:0] off, logic [4:0] rem,
                                     logic [5:0] blk, logic wrap);
    return {wrap, blk, rem, off, sb};
  endfunction

  function automatic logic [17:0] rep(int k);
    return {3{6'(k)}};
  endfunction

  function automatic logic [5:0] wa(int lb, int b);
    return wrAddr[(lb*3+b)*6 +: 6];
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(logic sel, logic [2:0] a, logic [16:0] d);
    @(negedge clk);
    hostWr = 1'b1; hostHeight = sel; hostAddr = a; hostData = d;
    @(negedge clk);
    hostWr = 1'b0; hostHeight = 1'b0;
  endtask

  task automatic doStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R7: closed until started)
    chk("R7 reset inReady", 64'(inReady), 64'd0);
    chk("R2 reset blkAck", 64'(blkAck), 64'd0);
    chk("R5 reset rdAddr", 64'(rdAddr), 64'd0);

    // list for 44-pixel lines, 16-pixel blocks: period of 4 words
    hostWrite(1'b0, 3'd0, mk(2'd0, 3'd0, 5'd4,  6'd3, 1'b0));
    hostWrite(1'b0, 3'd1, mk(2'd2, 3'd4, 5'd8,  6'd3, 1'b0));
    hostWrite(1'b0, 3'd2, mk(2'd1, 3'd0, 5'd12, 6'd3, 1'b0));
    hostWrite(1'b0, 3'd3, mk(2'd0, 3'd4, 5'd0,  6'd2, 1'b1));
    hostWrite(1'b1, 3'd0, 17'd6);
    chk("R7 closed after host write", 64'(inReady), 64'd0);
    doStart();
    chk("R7 open one cycle after start", 64'(inReady), 64'd1);

    // walk the line table, one block per cycle
    for (int ln = 0; ln < 6; ln++) begin
      for (int k = 0; k < int'(LINES[ln].blk); k++) begin
        blkValid = 1'b1;
        @(negedge clk);
        chk("R2 blkAck", 64'(blkAck), 64'd1);
        chk("R2 firstBlk", 64'(firstBlk), 64'(k == 0));
        chk("R2 lastBlk", 64'(lastBlk), 64'(k == int'(LINES[ln].blk) - 1));
        chk("R4 curLb", 64'(curLb), 64'(LINES[ln].lb));
        chk("R1 R3 R8 startBank", 64'(startBank), 64'(LINES[ln].sb));
        chk("R1 R3 R8 bankOff", 64'(bankOff), 64'(LINES[ln].off));
        chk("R1 R3 R8 remCnt", 64'(remCnt), 64'(LINES[ln].rem));
        chk("R5 rdAddr", 64'(rdAddr), 64'(rep(k)));
        chk("R5 wrAddr of active buffer", 64'(wa(int'(LINES[ln].lb), 2)), 64'(k));
        if (k == 0 && ln > 0)
          chk("R5 previous buffer kept", 64'(wa(int'(LINES[ln-1].lb), 0)),
              64'(int'(LINES[ln-1].blk) - 1));
      end
    end
    blkValid = 1'b0;
    chk("R6 closed after height lines", 64'(inReady), 64'd0);

    // blocks offered while closed are ignored
    blkValid = 1'b1;
    @(negedge clk);
    blkValid = 1'b0;
    chk("R9 no ack while closed", 64'(blkAck), 64'd0);
    chk("R9 counters unchanged", 64'(rdAddr), 64'(rep(2)));
    chk("R9 lb0 counters unchanged", 64'(wa(0, 1)), 64'd1);

    // host write and start together: start ignored
    @(negedge clk);
    hostWr = 1'b1; hostHeight = 1'b1; hostData = 17'd3; start = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; hostHeight = 1'b0; start = 1'b0;
    chk("R7 start ignored with host write", 64'(inReady), 64'd0);

    // open, then a host write closes the input
    doStart();
    chk("R7 open after start", 64'(inReady), 64'd1);
    hostWrite(1'b0, 3'd0, mk(2'd1, 3'd2, 5'd0, 6'd1, 1'b1));
    chk("R7 host write closes", 64'(inReady), 64'd0);

    // one-word list of single-block lines, height 3
    doStart();
    for (int ln = 0; ln < 3; ln++) begin
      blkValid = 1'b1;
      @(negedge clk);
      chk("R2 single-block line first", 64'(firstBlk), 64'd1);
      chk("R2 single-block line last", 64'(lastBlk), 64'd1);
      chk("R3 wrap to word 0", 64'(startBank), 64'd1);
      chk("R3 wrap to word 0 offset", 64'(bankOff), 64'd2);
      chk("R4 curLb single-block", 64'(curLb), 64'(ln));
      chk("R5 single-block rdAddr", 64'(rdAddr), 64'd0);
    end
    blkValid = 1'b0;
    chk("R6 closed after 3 lines", 64'(inReady), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule